// File: doc/BRIEF.md
# Delayed video memory write queue

This block holds host data-port writes for a short, fixed time before they reach the video memories. Each accepted push records a target address, a 16-bit value, a 4-bit access code and a release time. The release time is the push instant plus three access slots, measured on a free-running master clock counter. The queue retires work only in external access slots that a separate scheduler marks, and it performs at most one memory operation per such slot.

There are three targets. The byte-wide VRAM needs two slots per word. The first slot writes the upper byte, and the entry stays at the head with a "partial" mark. The second slot writes the lower byte to the neighbouring byte address and retires the entry. Colour RAM and scroll RAM take a whole word in one slot. A scroll RAM write whose word index is beyond the physical size is dropped, and its entry still retires. After each slot the block reports whether that slot went unused. The host side is a ready/valid push port, and a push stalls while the four entries are occupied.

One `clk` cycle is one master clock. A slot is 16 master clocks in wide (40-cell) mode and 20 in narrow (32-cell) mode, so the latency is 48 or 60 master clocks.

Top module: `vram_write_queue`

## Requirements
- R1: After reset: `empty`=1, `full`=0, `pushReady`=1, `slotUnused`=0, and no write strobe is high.
- R2: An entry accepted at master count m may be serviced only by a slot whose start edge sees a count of at least m+48 if `wideMode` was 1 at the push, or m+60 if it was 0. `wideMode` is sampled only at the push.
- R3: The access code selects the target: 4'h1 is VRAM, 4'h3 is colour RAM and 4'h5 is scroll RAM. An entry with any other code retires in one serviced slot with no write.
- R4: The first serviced slot of a VRAM entry writes bits 15:8 of the value to the entry address. The entry stays queued (`empty`=0).
- R5: The next serviced slot of that entry writes bits 7:0 to the entry address with bit 0 inverted, then retires the entry.
- R6: A colour RAM entry writes its whole word to its address in one serviced slot and retires.
- R7: A scroll RAM entry uses the index (address>>1) mod 64. It writes only if that index is below 40. Otherwise nothing is written, and the entry still retires.
- R8: `slotUnused` changes only at a slot start. It becomes 1 after an external slot that finds the queue empty or the head not yet released. It becomes 0 after a serviced slot or after any non-external slot.
- R9: Write strobes pulse only in the cycle after an external slot start, and at most one of them is high at a time.
- R10: Entries retire in push order. At four entries `full`=1 and `pushReady`=0, and a held push is accepted only after a slot retires an entry.
- R11: The release comparison stays correct when the master counter wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wideMode | input | 1 | 1: 16-clock slots, 0: 20-clock slots (sampled at push) |
| slotStart | input | 1 | Pulse at the start of every access slot |
| slotExternal | input | 1 | Qualifies `slotStart` as an external access slot |
| pushValid | input | 1 | Host write request |
| pushReady | output | 1 | Queue can accept a push this cycle |
| pushAddr | input | 16 | Target address |
| pushData | input | 16 | Write value |
| pushCode | input | 4 | Access code (target select) |
| full | output | 1 | All entries occupied |
| empty | output | 1 | No entries queued |
| slotUnused | output | 1 | Last slot did no work |
| vramWe | output | 1 | VRAM byte write strobe |
| vramAddr | output | 16 | VRAM byte address |
| vramData | output | 8 | VRAM byte |
| cramWe | output | 1 | Colour RAM write strobe |
| cramAddr | output | 16 | Colour RAM address |
| cramData | output | 16 | Colour RAM word |
| vsramWe | output | 1 | Scroll RAM write strobe |
| vsramIdx | output | 6 | Scroll RAM word index |
| vsramData | output | 16 | Scroll RAM word |

## Verification
The bound checker watches several properties on every cycle:
- at most one memory strobe is high, and strobes appear only after a slot start;
- `slotUnused` holds between slot starts, clears on an internal slot and sets on an external slot that finds the queue empty;
- an idle, empty queue stays empty;
- no scroll RAM index at or above the size limit is ever written.

The exact release edge in both modes, the two-step VRAM byte order with the flipped address bit, and dropped scroll RAM indices that still retire can only be shown by the bench's timed scenarios. So can push order through a full queue and the stall of a held push. The bench runs the counter at 8 bits, so the vector walk crosses several counter wraps.

// File: rtl/vwq_pkg.sv
package vwq_pkg;

  // Target select values carried in the access code
  localparam logic [3:0] CODE_VRAM_WR  = 4'h1;
  localparam logic [3:0] CODE_CRAM_WR  = 4'h3;
  localparam logic [3:0] CODE_VSRAM_WR = 4'h5;

  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic writeHi;     // VRAM upper byte, keep entry
    logic writeLo;     // VRAM lower byte at address^1
    logic writeCram;   // full word to colour RAM
    logic writeVsram;  // full word to scroll RAM
    logic setPartial;  // mark head as half done
    logic pop;         // retire head entry
    logic clearUnused; // a slot starts: refresh the unused flag
    logic markUnused;  // new value of the unused flag
  } vwq_strobes_t;

endpackage

// File: rtl/vwq_ctrl.sv
module vwq_ctrl
  import vwq_pkg::*;
(
  input  logic         slotStart,
  input  logic         slotExternal,
  input  logic         headValid,
  input  logic         headReleased,
  input  logic [3:0]   headCode,
  input  logic         headPartial,
  input  logic         headVsramOk,
  output vwq_strobes_t str
);

  logic service;

  assign service = slotStart & slotExternal & headValid & headReleased;

  always_comb begin
    str = '0;
    str.clearUnused = slotStart;
    str.markUnused  = slotStart & slotExternal & ~service;
    if (service) begin
      unique case (headCode)
        CODE_VRAM_WR: begin
          if (headPartial) begin
            str.writeLo = 1'b1;
            str.pop     = 1'b1;
          end else begin
            str.writeHi    = 1'b1;
            str.setPartial = 1'b1;
          end
        end
        CODE_CRAM_WR: begin
          str.writeCram = 1'b1;
          str.pop       = 1'b1;
        end
        CODE_VSRAM_WR: begin
          str.writeVsram = headVsramOk;
          str.pop        = 1'b1;
        end
        default: str.pop = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/vwq_datapath.sv
module vwq_datapath
  import vwq_pkg::*;
#(
  parameter int DEPTH         = 4,
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int CNT_W         = 16,
  parameter int SLOT_WIDE     = 16,
  parameter int SLOT_NARROW   = 20,
  parameter int LATENCY_SLOTS = 3,
  parameter int VSRAM_WORDS   = 40,
  parameter int VSRAM_IDX_W   = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wideMode,
  input  logic                   pushValid,
  output logic                   pushReady,
  input  logic [ADDR_W-1:0]      pushAddr,
  input  logic [DATA_W-1:0]      pushData,
  input  logic [3:0]             pushCode,
  input  vwq_strobes_t           str,
  output logic                   headValid,
  output logic                   headReleased,
  output logic [3:0]             headCode,
  output logic                   headPartial,
  output logic                   headVsramOk,
  output logic                   full,
  output logic                   empty,
  output logic                   slotUnused,
  output logic                   vramWe,
  output logic [ADDR_W-1:0]      vramAddr,
  output logic [DATA_W/2-1:0]    vramData,
  output logic                   cramWe,
  output logic [ADDR_W-1:0]      cramAddr,
  output logic [DATA_W-1:0]      cramData,
  output logic                   vsramWe,
  output logic [VSRAM_IDX_W-1:0] vsramIdx,
  output logic [DATA_W-1:0]      vsramData
);

  localparam int BYTE_W = DATA_W / 2;
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_BITS = $clog2(DEPTH + 1);
  localparam logic [CNT_BITS-1:0] DEPTH_C = CNT_BITS'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] LAT_WIDE   = CNT_W'(LATENCY_SLOTS * SLOT_WIDE);
  localparam logic [CNT_W-1:0] LAT_NARROW = CNT_W'(LATENCY_SLOTS * SLOT_NARROW);
  localparam logic [VSRAM_IDX_W:0] VSRAM_LIM = (VSRAM_IDX_W + 1)'(VSRAM_WORDS);

  // Free-running master clock count
  logic [CNT_W-1:0] mclk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mclk <= '0;
    else        mclk <= mclk + 1'b1;
  end

  // Entry storage
  logic [CNT_W-1:0]  relArr  [DEPTH];
  logic [ADDR_W-1:0] addrArr [DEPTH];
  logic [DATA_W-1:0] dataArr [DEPTH];
  logic [3:0]        codeArr [DEPTH];
  logic [DEPTH-1:0]  partVec;

  logic [PTR_W-1:0]    rdPtr, wrPtr;
  logic [CNT_BITS-1:0] count;
  logic                pushFire;
  logic [CNT_W-1:0]    releaseAt;
  logic [CNT_W-1:0]    relDiff;
  logic [ADDR_W-1:0]   headAddr;
  logic [DATA_W-1:0]   headData;
  logic [VSRAM_IDX_W-1:0] headIdx;

  assign full      = (count == DEPTH_C);
  assign empty     = (count == '0);
  assign pushReady = ~full;
  assign pushFire  = pushValid & pushReady;
  assign releaseAt = mclk + (wideMode ? LAT_WIDE : LAT_NARROW);

  assign headValid    = ~empty;
  assign headAddr     = addrArr[rdPtr];
  assign headData     = dataArr[rdPtr];
  assign headCode     = codeArr[rdPtr];
  assign headPartial  = partVec[rdPtr];
  // Wrap-safe: released when (now - release) is non-negative as a signed value
  assign relDiff      = mclk - relArr[rdPtr];
  assign headReleased = ~relDiff[CNT_W-1];
  assign headIdx      = headAddr[VSRAM_IDX_W:1];
  assign headVsramOk  = ({1'b0, headIdx} < VSRAM_LIM);

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushFire) begin
      relArr[wrPtr]  <= releaseAt;
      addrArr[wrPtr] <= pushAddr;
      dataArr[wrPtr] <= pushData;
      codeArr[wrPtr] <= pushCode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      partVec <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (pushFire && wrPtr == PTR_W'(i))
          partVec[i] <= 1'b0;
        else if (str.setPartial && rdPtr == PTR_W'(i))
          partVec[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (pushFire) wrPtr <= nextPtr(wrPtr);
      if (str.pop)  rdPtr <= nextPtr(rdPtr);
      unique case ({pushFire, str.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // Registered memory side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotUnused <= 1'b0;
      vramWe     <= 1'b0;
      vramAddr   <= '0;
      vramData   <= '0;
      cramWe     <= 1'b0;
      cramAddr   <= '0;
      cramData   <= '0;
      vsramWe    <= 1'b0;
      vsramIdx   <= '0;
      vsramData  <= '0;
    end else begin
      if (str.clearUnused) slotUnused <= str.markUnused;
      vramWe  <= str.writeHi | str.writeLo;
      cramWe  <= str.writeCram;
      vsramWe <= str.writeVsram;
      if (str.writeHi) begin
        vramAddr <= headAddr;
        vramData <= headData[DATA_W-1:BYTE_W];
      end else if (str.writeLo) begin
        vramAddr <= headAddr ^ ADDR_W'(1);
        vramData <= headData[BYTE_W-1:0];
      end
      if (str.writeCram) begin
        cramAddr <= headAddr;
        cramData <= headData;
      end
      if (str.writeVsram) begin
        vsramIdx  <= headIdx;
        vsramData <= headData;
      end
    end
  end

endmodule

// File: rtl/vram_write_queue.sv
module vram_write_queue
  import vwq_pkg::*;
#(
  parameter int DEPTH         = 4,
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int CNT_W         = 16,
  parameter int SLOT_WIDE     = 16,
  parameter int SLOT_NARROW   = 20,
  parameter int LATENCY_SLOTS = 3,
  parameter int VSRAM_WORDS   = 40,
  parameter int VSRAM_IDX_W   = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wideMode,
  input  logic                   slotStart,
  input  logic                   slotExternal,
  input  logic                   pushValid,
  output logic                   pushReady,
  input  logic [ADDR_W-1:0]      pushAddr,
  input  logic [DATA_W-1:0]      pushData,
  input  logic [3:0]             pushCode,
  output logic                   full,
  output logic                   empty,
  output logic                   slotUnused,
  output logic                   vramWe,
  output logic [ADDR_W-1:0]      vramAddr,
  output logic [DATA_W/2-1:0]    vramData,
  output logic                   cramWe,
  output logic [ADDR_W-1:0]      cramAddr,
  output logic [DATA_W-1:0]      cramData,
  output logic                   vsramWe,
  output logic [VSRAM_IDX_W-1:0] vsramIdx,
  output logic [DATA_W-1:0]      vsramData
);

  vwq_strobes_t str;
  logic         headValid, headReleased, headPartial, headVsramOk;
  logic [3:0]   headCode;

  vwq_ctrl u_ctrl (
    .slotStart    (slotStart),
    .slotExternal (slotExternal),
    .headValid    (headValid),
    .headReleased (headReleased),
    .headCode     (headCode),
    .headPartial  (headPartial),
    .headVsramOk  (headVsramOk),
    .str          (str)
  );

  vwq_datapath #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .SLOT_WIDE(SLOT_WIDE), .SLOT_NARROW(SLOT_NARROW),
    .LATENCY_SLOTS(LATENCY_SLOTS), .VSRAM_WORDS(VSRAM_WORDS),
    .VSRAM_IDX_W(VSRAM_IDX_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .wideMode(wideMode),
    .pushValid(pushValid), .pushReady(pushReady),
    .pushAddr(pushAddr), .pushData(pushData), .pushCode(pushCode),
    .str(str),
    .headValid(headValid), .headReleased(headReleased), .headCode(headCode),
    .headPartial(headPartial), .headVsramOk(headVsramOk),
    .full(full), .empty(empty), .slotUnused(slotUnused),
    .vramWe(vramWe), .vramAddr(vramAddr), .vramData(vramData),
    .cramWe(cramWe), .cramAddr(cramAddr), .cramData(cramData),
    .vsramWe(vsramWe), .vsramIdx(vsramIdx), .vsramData(vsramData)
  );

endmodule

// File: rtl/vwq_chk.sv
module vwq_chk #(
  parameter int VSRAM_WORDS = 40,
  parameter int VSRAM_IDX_W = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   slotStart,
  input logic                   slotExternal,
  input logic                   pushValid,
  input logic                   full,
  input logic                   empty,
  input logic                   slotUnused,
  input logic                   vramWe,
  input logic                   cramWe,
  input logic                   vsramWe,
  input logic [VSRAM_IDX_W-1:0] vsramIdx
);

  localparam logic [VSRAM_IDX_W:0] LIM = (VSRAM_IDX_W + 1)'(VSRAM_WORDS);

  // R9
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vramWe, cramWe, vsramWe}));

  // R9
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slotStart |=> !(vramWe || cramWe || vsramWe));

  // R8
  unused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slotStart |=> $stable(slotUnused));

  // R8
  internal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slotStart && !slotExternal) |=> !slotUnused);

  // R8
  empty_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slotStart && slotExternal && empty) |=> slotUnused);

  // R10
  full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R10
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !pushValid) |=> empty);

  // R7
  vsram_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsramWe |-> ({1'b0, vsramIdx} < LIM));

endmodule

bind vram_write_queue vwq_chk #(
  .VSRAM_WORDS(VSRAM_WORDS), .VSRAM_IDX_W(VSRAM_IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slotStart(slotStart), .slotExternal(slotExternal),
  .pushValid(pushValid), .full(full), .empty(empty), .slotUnused(slotUnused),
  .vramWe(vramWe), .cramWe(cramWe), .vsramWe(vsramWe), .vsramIdx(vsramIdx)
);

// File: tb/vram_write_queue_tb.sv
module vram_write_queue_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wideMode = 1'b1;
  logic        slotStart = 1'b0;
  logic        slotExternal = 1'b0;
  logic        pushValid = 1'b0;
  logic        pushReady;
  logic [15:0] pushAddr = '0;
  logic [15:0] pushData = '0;
  logic [3:0]  pushCode = '0;
  logic        full, empty, slotUnused;
  logic        vramWe, cramWe, vsramWe;
  logic [15:0] vramAddr, cramAddr, cramData, vsramData;
  logic [7:0]  vramData;
  logic [5:0]  vsramIdx;

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  int pushCyc = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  // 8-bit counter so the run crosses many wraps (R11)
  vram_write_queue #(.CNT_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wideMode(wideMode),
    .slotStart(slotStart), .slotExternal(slotExternal),
    .pushValid(pushValid), .pushReady(pushReady),
    .pushAddr(pushAddr), .pushData(pushData), .pushCode(pushCode),
    .full(full), .empty(empty), .slotUnused(slotUnused),
    .vramWe(vramWe), .vramAddr(vramAddr), .vramData(vramData),
    .cramWe(cramWe), .cramAddr(cramAddr), .cramData(cramData),
    .vsramWe(vsramWe), .vsramIdx(vsramIdx), .vsramData(vsramData)
  );

  // {wide, code, addr, data}
  localparam int NV = 9;
  localparam logic [36:0] VECS [NV] = '{
    {1'b1, 4'h1, 16'h1234, 16'hABCD},
    {1'b0, 4'h1, 16'h0007, 16'h5A3C},
    {1'b1, 4'h3, 16'h0022, 16'h0EEE},
    {1'b0, 4'h5, 16'h004E, 16'h0123},
    {1'b1, 4'h5, 16'h0050, 16'h0777},
    {1'b1, 4'h5, 16'h0082, 16'h0456},
    {1'b0, 4'h0, 16'h0010, 16'hFFFF},
    {1'b1, 4'h5, 16'h00FE, 16'h0999},
    {1'b0, 4'h3, 16'h007F, 16'h0F0F}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] strobes();
    return {vramWe, cramWe, vsramWe};
  endfunction

  task automatic doPush(input logic w, input logic [3:0] c,
                        input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wideMode = w; pushCode = c; pushAddr = a; pushData = d; pushValid = 1'b1;
    while (!pushReady) @(negedge clk);
    @(negedge clk);
    pushCyc = cyc;
    pushValid = 1'b0;
  endtask

  // Slot start at the edge that is k edges after the last accepted push
  task automatic slotAt(input int k, input logic ext);
    while (cyc + 1 < pushCyc + k) @(negedge clk);
    slotStart = 1'b1; slotExternal = ext;
    @(negedge clk);
    slotStart = 1'b0; slotExternal = 1'b0;
  endtask

  task automatic slotNow(input logic ext);
    slotStart = 1'b1; slotExternal = ext;
    @(negedge clk);
    slotStart = 1'b0; slotExternal = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "empty", empty, 1);
    chk("R1", "full", full, 0);
    chk("R1", "pushReady", pushReady, 1);
    chk("R1", "slotUnused", slotUnused, 0);
    chk("R1", "strobes", strobes(), 0);

    // R8 external slot with empty queue
    slotNow(1'b1);
    chk("R8", "unused on empty", slotUnused, 1);
    chk("R9", "no write on empty", strobes(), 0);

    // Vector walk (R2 R11 timing plus R3..R7 target rules)
    for (int i = 0; i < NV; i++) begin
      logic        w;
      logic [3:0]  c;
      logic [15:0] a, d;
      int          lat;
      logic [5:0]  idx;
      {w, c, a, d} = VECS[i];
      lat = w ? 48 : 60;
      idx = a[6:1];
      doPush(w, c, a, d);
      slotAt(lat - 1, 1'b1);
      chk("R2 R11", "no write before release", strobes(), 0);
      chk("R8", "unused before release", slotUnused, 1);
      chk("R2", "still queued", empty, 0);
      slotAt(lat, 1'b1);
      chk("R8", "serviced slot not unused", slotUnused, 0);
      case (c)
        4'h1: begin
          chk("R4", "vram hi strobe", strobes(), 3'b100);
          chk("R4", "vram hi addr", vramAddr, a);
          chk("R4", "vram hi byte", vramData, d[15:8]);
          chk("R4", "entry kept", empty, 0);
          slotAt(lat + 1, 1'b1);
          chk("R5", "vram lo strobe", strobes(), 3'b100);
          chk("R5", "vram lo addr", vramAddr, a ^ 16'h0001);
          chk("R5", "vram lo byte", vramData, d[7:0]);
          chk("R5", "popped", empty, 1);
        end
        4'h3: begin
          chk("R6", "cram strobe", strobes(), 3'b010);
          chk("R6", "cram addr", cramAddr, a);
          chk("R6", "cram data", cramData, d);
          chk("R6", "popped", empty, 1);
        end
        4'h5: begin
          if (idx < 6'd40) begin
            chk("R7", "vsram strobe", strobes(), 3'b001);
            chk("R7", "vsram idx", vsramIdx, idx);
            chk("R7", "vsram data", vsramData, d);
          end else begin
            chk("R7", "vsram dropped", strobes(), 0);
          end
          chk("R7", "popped", empty, 1);
        end
        default: begin
          chk("R3", "no write for other code", strobes(), 0);
          chk("R3", "popped", empty, 1);
        end
      endcase
    end

    // R2: mode change after the push does not move the release point
    doPush(1'b1, 4'h3, 16'h0040, 16'h0ABC);
    @(negedge clk);
    wideMode = 1'b0;
    slotAt(47, 1'b1);
    chk("R2", "wide latched, early", strobes(), 0);
    slotAt(48, 1'b1);
    chk("R2", "wide latched, on time", cramData, 16'h0ABC);

    // R8/R9: internal slot does nothing and clears unused
    doPush(1'b1, 4'h3, 16'h0044, 16'h0111);
    slotAt(47, 1'b1);
    chk("R8", "unused set", slotUnused, 1);
    slotAt(60, 1'b0);
    chk("R8", "internal slot clears unused", slotUnused, 0);
    chk("R9", "internal slot writes nothing", strobes(), 0);
    chk("R9", "entry kept", empty, 0);
    slotNow(1'b1);
    chk("R9", "next external slot writes", cramData, 16'h0111);

    // R10: fill, stall, order
    for (int j = 0; j < 4; j++) doPush(1'b1, 4'h3, 16'(j * 2), 16'h0C00 + 16'(j));
    chk("R10", "full", full, 1);
    chk("R10", "ready low", pushReady, 0);
    @(negedge clk);
    pushCode = 4'h3; pushAddr = 16'h0008; pushData = 16'h0C04; pushValid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "held push stalls", full, 1);
    slotAt(48, 1'b1);
    chk("R10", "first out", cramData, 16'h0C00);
    chk("R10", "ready after pop", pushReady, 1);
    @(negedge clk);
    pushValid = 1'b0;
    pushCyc = cyc;
    chk("R10", "held push accepted", full, 1);
    slotAt(48, 1'b1);
    for (int j = 1; j < 5; j++) begin
      if (j > 1) slotNow(1'b1);
      chk("R10", "push order", cramData, 16'h0C00 + 16'(j));
    end
    chk("R10", "drained", empty, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule